// File: doc/BRIEF.md
# Polled Byte-Peripheral Port

This block connects a simple processor bus to one byte-wide external device. The processor addresses the port with a bus cycle that carries an address, a two-bit operation code and a data byte. The port acts only on its own address. It supports four operations:

- a configuration write,
- a status query,
- a fetch of a received character,
- a send of a character.

Each query and each fetch returns a registered reply one cycle later.

On the device side there are two valid/ready channels, one in each direction. Each carries seven data bits with an even-parity bit in bit 7. Every direction has a single-character holding register, so the device and the processor can run at unrelated rates. Software works by polling. It reads status, fetches a character once READY is set, and sends a character once BUSY is clear. A configuration bit can also raise an interrupt request while a received character is waiting.

Top module: `pio_port`

## Requirements
- R1: A bus cycle whose address differs from the parameter MY_ADDR has no effect on any state or output, and no reply follows it.
- R2: Operation codes are 00 configure, 01 status query, 10 fetch, 11 send. A status query or a fetch makes `cpu_rvalid` high for exactly the following cycle. The status byte is laid out as bit 0 READY, bit 1 BUSY, bit 2 PARITY_ERR, bit 3 DEVICE_ERR, bit 4 OVERRUN, with bits 7:5 zero.
- R3: A status query clears PARITY_ERR, DEVICE_ERR and OVERRUN after reporting them, unless the same cycle sets them again.
- R4: A configure cycle latches data bit 0 as receive-enable and data bit 1 as interrupt-enable. `dev_in_ready` is high exactly when receive is enabled and the receive holder is empty.
- R5: A character accepted from the device is stored, sets READY, and drops `dev_in_ready` until it is fetched.
- R6: A fetch while READY returns {0, seven data bits} and clears READY. A fetch while not READY returns 0x00 and changes nothing.
- R7: A received byte with an odd number of ones across all eight bits sets PARITY_ERR. Its data bits are still stored.
- R8: A send while not BUSY presents {even-parity bit, data bits 6:0} on `dev_out_data` with `dev_out_valid` high. BUSY stays set until a cycle in which both valid and ready are high. Data bit 7 of the send is ignored.
- R9: A send while BUSY is ignored, sets OVERRUN, and leaves the pending output byte unchanged.
- R10: `dev_fault` high in any cycle sets DEVICE_ERR, which then holds until a status query clears it.
- R11: `irq` is high exactly when interrupt-enable is set and READY is high.
- R12: After reset the status is 0x00 and both enables are clear. `dev_in_ready`, `dev_out_valid`, `irq` and `cpu_rvalid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Bus cycle present |
| cpu_addr | input | ADDR_W | Bus address |
| cpu_cmd | input | 2 | Operation code |
| cpu_wdata | input | CHAR_W+1 | Configure or send data |
| cpu_rvalid | output | 1 | Reply valid, one cycle after query or fetch |
| cpu_rdata | output | CHAR_W+1 | Status byte or fetched character |
| irq | output | 1 | Interrupt request |
| dev_in_valid | input | 1 | Device offers a received byte |
| dev_in_data | input | CHAR_W+1 | Received byte, parity in top bit |
| dev_in_ready | output | 1 | Port can take a received byte |
| dev_out_valid | output | 1 | Port offers a byte to the device |
| dev_out_data | output | CHAR_W+1 | Byte to the device, parity in top bit |
| dev_out_ready | input | 1 | Device takes the offered byte |
| dev_fault | input | 1 | Device malfunction indication |

## Verification
The assertions assume that `dev_in_valid` and `dev_fault` are driven to known values while reset is released. They also assume that a device holding `dev_out_ready` low leaves the port free to keep its output steady. They take no position on whether the device keeps its offer stable.

The bench drives every input at the falling edge. It raises `dev_in_valid` only while it waits for `dev_in_ready` and drops it one cycle after the handshake. It pulses `dev_out_ready` for a single cycle only while a byte is pending. This keeps every handshake a clean single transfer.

// File: rtl/pio_pkg.sv
// Shared definitions for the polled byte-peripheral port.
// Assumes nothing beyond a two-bit operation code on the bus.
package pio_pkg;
    typedef enum logic [1:0] {
        OP_CONFIG = 2'b00,
        OP_QUERY  = 2'b01,
        OP_FETCH  = 2'b10,
        OP_SEND   = 2'b11
    } pio_op_e;

    localparam int ST_READY  = 0;
    localparam int ST_BUSY   = 1;
    localparam int ST_PARERR = 2;
    localparam int ST_DEVERR = 3;
    localparam int ST_OVRUN  = 4;
    localparam int ST_NBITS  = 5;

    localparam int CFG_RXEN  = 0;
    localparam int CFG_IRQEN = 1;
endpackage

// File: rtl/pio_decode.sv
// Address match and operation decode for one bus cycle.
// Purely combinational; assumes cpu_cmd is meaningful only with cpu_valid.
module pio_decode
    import pio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MY_ADDR = 'h40
) (
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_cmd,
    output logic              hit,
    output logic              do_config,
    output logic              do_query,
    output logic              do_fetch,
    output logic              do_send
);
    // Select the one operation the matching cycle requests.
    always_comb begin
        hit       = cpu_valid && (cpu_addr == MY_ADDR);
        do_config = hit && (pio_op_e'(cpu_cmd) == OP_CONFIG);
        do_query  = hit && (pio_op_e'(cpu_cmd) == OP_QUERY);
        do_fetch  = hit && (pio_op_e'(cpu_cmd) == OP_FETCH);
        do_send   = hit && (pio_op_e'(cpu_cmd) == OP_SEND);
    end
endmodule

// File: rtl/pio_rx.sv
// Receive holder: accepts one byte from the device, checks even parity
// across all bits and keeps the data bits until the processor fetches them.
// Assumes take is asserted only for a fetch cycle.
module pio_rx #(
    parameter int CHAR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [CHAR_W:0]   in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] char_q,
    output logic              par_bad
);
    logic accept;

    // Offer space only when enabled and empty; flag bad parity on accept.
    always_comb begin
        in_ready = enable && !full;
        accept   = in_valid && in_ready;
        par_bad  = accept && (^in_data);
    end

    // Hold the received character and its occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            char_q <= '0;
        end else if (accept) begin
            full   <= 1'b1;
            char_q <= in_data[CHAR_W-1:0];
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    a_r5_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (full && !in_ready));
    a_r6_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full) |=> !full);
    a_r5_hold_char: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> ($stable(char_q) && full));
endmodule

// File: rtl/pio_tx.sv
// Send holder: takes one character from the processor, appends an even
// parity bit and offers it to the device until the device accepts it.
// Assumes load is raised only while not busy.
module pio_tx #(
    parameter int CHAR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_char,
    output logic              out_valid,
    output logic [CHAR_W:0]   out_data,
    input  logic              out_ready
);
    // Capture a new byte with parity, release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= {^load_char, load_char};
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r8_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(^out_data));
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/pio_port.sv
// Polled byte-peripheral port: decodes its own bus address, keeps the
// configuration and sticky error bits, builds the status byte and
// returns registered replies. Assumes CHAR_W+1 >= 5 so status fits.
module pio_port
    import pio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MY_ADDR = 'h40,
    parameter int CHAR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_cmd,
    input  logic [CHAR_W:0]   cpu_wdata,
    output logic              cpu_rvalid,
    output logic [CHAR_W:0]   cpu_rdata,
    output logic              irq,
    input  logic              dev_in_valid,
    input  logic [CHAR_W:0]   dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [CHAR_W:0]   dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_fault
);
    localparam int BYTE_W = CHAR_W + 1;

    logic              hit, do_config, do_query, do_fetch, do_send;
    logic              rx_en_q, irq_en_q;
    logic              par_err_q, dev_err_q, ovr_q;
    logic              rx_full, par_bad, tx_busy, tx_load, rx_take;
    logic [CHAR_W-1:0] rx_char;
    logic [BYTE_W-1:0] status;
    logic              unused_wdata_top;

    assign unused_wdata_top = cpu_wdata[CHAR_W];

    pio_decode #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_dec (
        .cpu_valid (cpu_valid),
        .cpu_addr  (cpu_addr),
        .cpu_cmd   (cpu_cmd),
        .hit       (hit),
        .do_config (do_config),
        .do_query  (do_query),
        .do_fetch  (do_fetch),
        .do_send   (do_send)
    );

    pio_rx #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_en_q),
        .in_valid (dev_in_valid),
        .in_data  (dev_in_data),
        .in_ready (dev_in_ready),
        .take     (rx_take),
        .full     (rx_full),
        .char_q   (rx_char),
        .par_bad  (par_bad)
    );

    pio_tx #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_char (cpu_wdata[CHAR_W-1:0]),
        .out_valid (dev_out_valid),
        .out_data  (dev_out_data),
        .out_ready (dev_out_ready)
    );

    // Gate the holders: sends only when idle, fetches only when full.
    always_comb begin
        tx_busy = dev_out_valid;
        tx_load = do_send && !tx_busy;
        rx_take = do_fetch && rx_full;
        irq     = irq_en_q && rx_full;
    end

    // Assemble the status byte from live flags and sticky errors.
    always_comb begin
        status            = '0;
        status[ST_READY]  = rx_full;
        status[ST_BUSY]   = tx_busy;
        status[ST_PARERR] = par_err_q;
        status[ST_DEVERR] = dev_err_q;
        status[ST_OVRUN]  = ovr_q;
    end

    // Latch the receive and interrupt enables on a configure cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q  <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (do_config) begin
            rx_en_q  <= cpu_wdata[CFG_RXEN];
            irq_en_q <= cpu_wdata[CFG_IRQEN];
        end
    end

    // Sticky error bits: a new event wins over the clear by a query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err_q <= 1'b0;
            dev_err_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            par_err_q <= par_bad | (par_err_q & ~do_query);
            dev_err_q <= dev_fault | (dev_err_q & ~do_query);
            ovr_q     <= (do_send & tx_busy) | (ovr_q & ~do_query);
        end
    end

    // Registered reply to a query or fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= do_query || do_fetch;
            if (do_query)
                cpu_rdata <= status;
            else if (rx_take)
                cpu_rdata <= {1'b0, rx_char};
            else
                cpu_rdata <= '0;
        end
    end

    a_r1_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !hit) |=> !cpu_rvalid);
    a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (do_send && tx_busy && !dev_out_ready) |=> (ovr_q && $stable(dev_out_data)));
    a_r3_query_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (do_query && !(do_send && tx_busy)) |=> !ovr_q);
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dev_fault |=> dev_err_q);
    a_r7_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_in_valid && dev_in_ready && (^dev_in_data)) |=> par_err_q);
    a_r2_reply_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(do_query || do_fetch));
endmodule

// File: tb/tb_pio_port.sv
`timescale 1ns/1ps
module tb_pio_port;
    localparam logic [7:0] ME    = 8'h40;
    localparam logic [7:0] OTHER = 8'h41;
    localparam logic [1:0] CFG = 2'b00, QRY = 2'b01, FET = 2'b10, SND = 2'b11;
    // Each entry: {byte sent by CPU, byte expected on the device side}.
    localparam logic [15:0] VEC [7] = '{16'h4141, 16'h43C3, 16'h0000,
                                        16'h7FFF, 16'hC141, 16'h5555, 16'h0787};

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cpu_valid = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [1:0] cpu_cmd = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rvalid, irq, dev_in_ready, dev_out_valid;
    logic [7:0] cpu_rdata, dev_out_data;
    logic       dev_in_valid = 1'b0, dev_out_ready = 1'b0, dev_fault = 1'b0;
    logic [7:0] dev_in_data = '0;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pio_port dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_cmd(cpu_cmd), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .irq(irq), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_fault(dev_fault)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [7:0] a, input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_cmd = op; cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic query(input string req, input logic [7:0] exp);
        bus(ME, QRY, 8'h00);
        chk(req, {7'b0, cpu_rvalid}, 8'h01);
        chk(req, cpu_rdata, exp);
    endtask

    task automatic dev_send(input logic [7:0] b);
        int g = 0;
        @(negedge clk);
        dev_in_valid = 1'b1; dev_in_data = b;
        while (!dev_in_ready && g < 50) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
        dev_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 rvalid", {7'b0, cpu_rvalid}, 8'h00);
        chk("R12 in_ready", {7'b0, dev_in_ready}, 8'h00);
        chk("R12 out_valid", {7'b0, dev_out_valid}, 8'h00);
        chk("R12 irq", {7'b0, irq}, 8'h00);
        query("R12 status", 8'h00);

        // R1: foreign address ignored
        bus(OTHER, SND, 8'h41);
        chk("R1 send ignored", {7'b0, dev_out_valid}, 8'h00);
        bus(OTHER, QRY, 8'h00);
        chk("R1 no reply", {7'b0, cpu_rvalid}, 8'h00);
        bus(OTHER, CFG, 8'h03);
        chk("R1 config ignored", {7'b0, dev_in_ready}, 8'h00);

        // R4: enable receive only
        bus(ME, CFG, 8'h01);
        chk("R4 in_ready", {7'b0, dev_in_ready}, 8'h01);
        chk("R11 irq off", {7'b0, irq}, 8'h00);

        // Vector table: send path then loopback of the same byte
        for (int i = 0; i < 7; i++) begin
            logic [7:0] w, e;
            w = VEC[i][15:8];
            e = VEC[i][7:0];
            bus(ME, SND, w);
            chk("R8 out_valid", {7'b0, dev_out_valid}, 8'h01);
            chk("R8 out_data", dev_out_data, e);
            if (i == 0) begin
                bus(ME, SND, 8'h7F);
                chk("R9 held data", dev_out_data, e);
                query("R9 overrun", 8'h12);
                query("R3 cleared", 8'h02);
            end else begin
                query("R8 busy", 8'h02);
            end
            @(negedge clk); dev_out_ready = 1'b1;
            @(negedge clk); dev_out_ready = 1'b0;
            chk("R8 released", {7'b0, dev_out_valid}, 8'h00);
            dev_send(e);
            chk("R5 in_ready low", {7'b0, dev_in_ready}, 8'h00);
            query("R5 ready", 8'h01);
            bus(ME, FET, 8'h00);
            chk("R6 fetch data", cpu_rdata, {1'b0, w[6:0]});
            query("R6 emptied", 8'h00);
        end

        // R6: fetch when empty
        bus(ME, FET, 8'h00);
        chk("R6 empty rvalid", {7'b0, cpu_rvalid}, 8'h01);
        chk("R6 empty data", cpu_rdata, 8'h00);

        // R7: odd parity
        dev_send(8'h01);
        query("R7 parity err", 8'h05);
        bus(ME, FET, 8'h00);
        chk("R7 data kept", cpu_rdata, 8'h01);
        query("R7 cleared", 8'h00);

        // R10: device fault pulse
        @(negedge clk); dev_fault = 1'b1;
        @(negedge clk); dev_fault = 1'b0;
        repeat (2) @(negedge clk);
        query("R10 dev err", 8'h08);
        query("R10 cleared", 8'h00);

        // R11: interrupt follows READY only with enable
        dev_send(8'hC1);
        chk("R11 irq masked", {7'b0, irq}, 8'h00);
        bus(ME, CFG, 8'h03);
        chk("R11 irq on", {7'b0, irq}, 8'h01);
        bus(ME, FET, 8'h00);
        chk("R11 fetch data", cpu_rdata, 8'h41);
        chk("R11 irq drops", {7'b0, irq}, 8'h00);

        // R4: disabling receive drops in_ready
        bus(ME, CFG, 8'h00);
        chk("R4 disabled", {7'b0, dev_in_ready}, 8'h00);

        finish_run();
    end
endmodule